// File: doc/BRIEF.md
# Two-Level Block Address Decoder

This block turns a 16-bit address and an address-valid strobe into active-low chip selects for five devices on a byte-wide external bus. A first 3-to-8 stage looks at the three top address bits and carves the space into eight 8 KB blocks. It is enabled only while the address is valid. One of its outputs enables a second 3-to-8 stage. The second stage looks at the next three address bits and splits that 8 KB block into eight 1 KB sub-blocks.

Two neighbouring first-stage outputs are merged by a negative-logic OR, which gives a single 16 KB select for a RAM. A 4 KB ROM owns a whole 8 KB block. The smaller devices each own a whole 1 KB sub-block. These devices are a 1 KB ROM, an ADC and an LCD. Address bits below the sub-block field are never looked at, so each device answers at every address of its region. Every decoder output that drives no device comes out on a spare-select bus, so it can serve later expansion. The block is purely combinational.

Top module: `blk_addr_decoder`

## Requirements
- R1: While addr_valid_i is 0, every output bit (all five device selects and all nine spare bits) is 1, whatever the address.
- R2: ram_cs_no is 0 exactly when addr_valid_i is 1 and addr_i[15:14] = 2'b01, which is the whole range 0x4000..0x7FFF.
- R3: rom_big_cs_no is 0 exactly when addr_valid_i is 1 and addr_i[15:13] = 3'b001, which is the whole range 0x2000..0x3FFF, although the device holds only 4 KB.
- R4: The second stage is active only when addr_valid_i is 1 and addr_i[15:13] = 3'b100 (0x8000..0x9FFF). Within that block, rom_small_cs_no is 0 exactly when addr_i[12:10] = 3'b000 (0x8000..0x83FF).
- R5: adc_cs_no is 0 for every address 0x8400..0x87FF, where addr_i[12:10] = 3'b001. lcd_cs_no is 0 for every address 0x8800..0x8BFF, where addr_i[12:10] = 3'b010. Bits addr_i[9:0] have no effect on either select.
- R6: While addr_valid_i is 1, exactly one of the fourteen output bits (five device selects plus nine spare bits) is 0.
- R7: The spare bus is spare_cs_no[8:0]. Bit 0 is low for block 0x0000..0x1FFF. Bits 1, 2 and 3 are low for blocks 0xA000..0xBFFF, 0xC000..0xDFFF and 0xE000..0xFFFF. Bits 4 to 8 are low for the sub-blocks 3 to 7 of the 0x8000 block, that is 0x8C00..0x8FFF up to 0x9C00..0x9FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Bus address |
| addr_valid_i | input | 1 | High while addr_i holds a valid address |
| ram_cs_no | output | 1 | 16 KB RAM select, active low |
| rom_big_cs_no | output | 1 | 4 KB ROM select, active low |
| rom_small_cs_no | output | 1 | 1 KB ROM select, active low |
| adc_cs_no | output | 1 | ADC select, active low |
| lcd_cs_no | output | 1 | LCD select, active low |
| spare_cs_no | output | 9 | Unused decoder outputs, active low |

## Verification
Every select is a pure function of the present address and strobe, so each result is due in the same cycle as its stimulus, with no register in the path. The bench changes the inputs on a rising edge and compares all fourteen outputs at the following falling edge, half a period later, when the logic has settled. Expected values come from a table of address ranges in the bench, not from bit fields. This table is applied to region edges, to an alias walk through the low bits, and to a sweep of the whole space with the strobe both high and low.

// File: rtl/blk_dec_pkg.sv
package blk_dec_pkg;

  function automatic int count_zeros(input int n, input longint unsigned used);
    int c = 0;
    for (int k = 0; k < n; k++) if (!used[k]) c++;
    return c;
  endfunction

  // position of output k among the unused outputs
  function automatic int spare_rank(input int k, input longint unsigned used);
    int c = 0;
    for (int j = 0; j < k; j++) if (!used[j]) c++;
    return c;
  endfunction

endpackage

// File: rtl/blk_dec_stage.sv
module blk_dec_stage #(
  parameter int DEC_W = 3,
  localparam int OUTS = 1 << DEC_W
) (
  input  logic             en_i,
  input  logic [DEC_W-1:0] sel_i,
  output logic [OUTS-1:0]  y_no
);
  for (genvar k = 0; k < OUTS; k++) begin : g_out
    assign y_no[k] = ~(en_i && (sel_i == DEC_W'(k)));
  end
endmodule

// File: rtl/blk_dec_merge.sv
module blk_dec_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] sel_ni,
  output logic         sel_no
);
  // negative-logic OR: low when any input is low
  assign sel_no = &sel_ni;
endmodule

// File: rtl/blk_dec_spare.sv
module blk_dec_spare #(
  parameter int              N    = 8,
  parameter longint unsigned USED = 0,
  localparam int             SW   = blk_dec_pkg::count_zeros(N, USED)
) (
  input  logic [N-1:0]  y_ni,
  output logic [SW-1:0] spare_no
);
  for (genvar k = 0; k < N; k++) begin : g_sp
    if (!USED[k]) begin : g_take
      assign spare_no[blk_dec_pkg::spare_rank(k, USED)] = y_ni[k];
    end
  end
endmodule

// File: rtl/blk_addr_decoder.sv
module blk_addr_decoder #(
  parameter int ADDR_W    = 16,
  parameter int DEC_W     = 3,
  parameter int RAM_BLK   = 2,
  parameter int ROMB_BLK  = 1,
  parameter int SUB_BLK   = 4,
  parameter int ROMS_SUB  = 0,
  parameter int ADC_SUB   = 1,
  parameter int LCD_SUB   = 2,
  localparam int OUTS     = 1 << DEC_W,
  localparam int SPARE_W  = 2 * OUTS - 7
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               addr_valid_i,
  output logic               ram_cs_no,
  output logic               rom_big_cs_no,
  output logic               rom_small_cs_no,
  output logic               adc_cs_no,
  output logic               lcd_cs_no,
  output logic [SPARE_W-1:0] spare_cs_no
);
  localparam int TOP_LSB = ADDR_W - DEC_W;
  localparam int SUB_LSB = TOP_LSB - DEC_W;
  localparam longint unsigned USED1 =
      (longint'(1) << RAM_BLK) | (longint'(1) << (RAM_BLK + 1)) |
      (longint'(1) << ROMB_BLK) | (longint'(1) << SUB_BLK);
  localparam longint unsigned USED2 =
      (longint'(1) << ROMS_SUB) | (longint'(1) << ADC_SUB) | (longint'(1) << LCD_SUB);
  localparam int SP1_W = OUTS - 4;
  localparam int SP2_W = OUTS - 3;

  logic [OUTS-1:0]  s1_n, s2_n;
  logic             sub_en;
  logic [SP1_W-1:0] sp1_n;
  logic [SP2_W-1:0] sp2_n;

  blk_dec_stage #(.DEC_W(DEC_W)) u_top (
    .en_i (addr_valid_i),
    .sel_i(addr_i[ADDR_W-1:TOP_LSB]),
    .y_no (s1_n)
  );

  assign sub_en = ~s1_n[SUB_BLK];

  blk_dec_stage #(.DEC_W(DEC_W)) u_sub (
    .en_i (sub_en),
    .sel_i(addr_i[TOP_LSB-1:SUB_LSB]),
    .y_no (s2_n)
  );

  blk_dec_merge #(.N(2)) u_ram (
    .sel_ni(s1_n[RAM_BLK+1:RAM_BLK]),
    .sel_no(ram_cs_no)
  );

  assign rom_big_cs_no   = s1_n[ROMB_BLK];
  assign rom_small_cs_no = s2_n[ROMS_SUB];
  assign adc_cs_no       = s2_n[ADC_SUB];
  assign lcd_cs_no       = s2_n[LCD_SUB];

  blk_dec_spare #(.N(OUTS), .USED(USED1)) u_sp1 (.y_ni(s1_n), .spare_no(sp1_n));
  blk_dec_spare #(.N(OUTS), .USED(USED2)) u_sp2 (.y_ni(s2_n), .spare_no(sp2_n));

  assign spare_cs_no = {sp2_n, sp1_n};
endmodule

// File: rtl/blk_dec_chk.sv
module blk_dec_chk #(
  parameter int ADDR_W  = 16,
  parameter int DEC_W   = 3,
  parameter int SUB_BLK = 4,
  localparam int OUTS    = 1 << DEC_W,
  localparam int SPARE_W = 2 * OUTS - 7
) (
  input logic [ADDR_W-1:0]  addr_i,
  input logic               addr_valid_i,
  input logic               ram_cs_no,
  input logic               rom_big_cs_no,
  input logic               rom_small_cs_no,
  input logic               adc_cs_no,
  input logic               lcd_cs_no,
  input logic [SPARE_W-1:0] spare_cs_no,
  input logic [OUTS-1:0]    s1_n,
  input logic [OUTS-1:0]    s2_n
);
  localparam int TOP_LSB = ADDR_W - DEC_W;
  logic [SPARE_W+4:0] all_n;
  assign all_n = {spare_cs_no, lcd_cs_no, adc_cs_no, rom_small_cs_no, rom_big_cs_no, ram_cs_no};

  always_comb begin
    assert_idle_high_R1: assert (addr_valid_i || &all_n)
      else $error("R1: select low without valid address");
    assert_ram_range_R2: assert (ram_cs_no == !(addr_valid_i && addr_i[ADDR_W-1 -: 2] == 2'b01))
      else $error("R2: RAM select mismatch");
    assert_sub_gate_R4: assert (&s2_n || (addr_valid_i && addr_i[ADDR_W-1:TOP_LSB] == DEC_W'(SUB_BLK)))
      else $error("R4: second stage active outside its block");
    assert_stage_onehot_R6: assert ($onehot0(~s1_n) && $onehot0(~s2_n))
      else $error("R6: stage has more than one low output");
    assert_one_select_R6: assert (!addr_valid_i || $countones(~all_n) == 1)
      else $error("R6: not exactly one select low");
  end
endmodule

bind blk_addr_decoder blk_dec_chk #(.ADDR_W(ADDR_W), .DEC_W(DEC_W), .SUB_BLK(SUB_BLK)) u_chk (
  .addr_i(addr_i), .addr_valid_i(addr_valid_i), .ram_cs_no(ram_cs_no),
  .rom_big_cs_no(rom_big_cs_no), .rom_small_cs_no(rom_small_cs_no),
  .adc_cs_no(adc_cs_no), .lcd_cs_no(lcd_cs_no), .spare_cs_no(spare_cs_no),
  .s1_n(s1_n), .s2_n(s2_n)
);

// File: tb/tb_blk_addr_decoder.sv
module tb_blk_addr_decoder;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic [15:0] addr = '0;
  logic        valid = 0;
  logic        ram_n, romb_n, roms_n, adc_n, lcd_n;
  logic [8:0]  spare_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  blk_addr_decoder dut (
    .addr_i(addr), .addr_valid_i(valid), .ram_cs_no(ram_n),
    .rom_big_cs_no(romb_n), .rom_small_cs_no(roms_n),
    .adc_cs_no(adc_n), .lcd_cs_no(lcd_n), .spare_cs_no(spare_n)
  );

  // {spare[8:0], lcd, adc, rom_small, rom_big, ram}, from the range table
  function automatic logic [13:0] model(input logic [15:0] a, input logic v);
    logic [13:0] e = '1;
    int u = int'(a);
    if (!v) return e;
    if      (u >= 'h4000 && u <= 'h7FFF) e[0]  = 0;
    else if (u >= 'h2000 && u <= 'h3FFF) e[1]  = 0;
    else if (u >= 'h8000 && u <= 'h83FF) e[2]  = 0;
    else if (u >= 'h8400 && u <= 'h87FF) e[3]  = 0;
    else if (u >= 'h8800 && u <= 'h8BFF) e[4]  = 0;
    else if (u <  'h2000)                e[5]  = 0;
    else if (u >= 'hA000 && u <= 'hBFFF) e[6]  = 0;
    else if (u >= 'hC000 && u <= 'hDFFF) e[7]  = 0;
    else if (u >= 'hE000)                e[8]  = 0;
    else                                 e[9 + (u - 'h8C00) / 'h400] = 0;
    return e;
  endfunction

  task automatic apply(input logic [15:0] a, input logic v, input string tag);
    logic [13:0] got, exp;
    @(posedge clk);
    addr  <= a;
    valid <= v;
    @(negedge clk);
    got = {spare_n, lcd_n, adc_n, roms_n, romb_n, ram_n};
    exp = model(a, v);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h valid=%b got=%b exp=%b", tag, a, v, got, exp);
    end
  endtask

  task automatic t_reset_idle();   // R1
    apply(16'h0000, 0, "R1");
    apply(16'h4000, 0, "R1");
    apply(16'h8400, 0, "R1");
    apply(16'hFFFF, 0, "R1");
  endtask

  task automatic t_ram();          // R2
    apply(16'h3FFF, 1, "R2");
    apply(16'h4000, 1, "R2");
    apply(16'h5FFF, 1, "R2");
    apply(16'h6000, 1, "R2");
    apply(16'h7FFF, 1, "R2");
    apply(16'h8000, 1, "R2");
  endtask

  task automatic t_rom_big();      // R3
    apply(16'h1FFF, 1, "R3");
    apply(16'h2000, 1, "R3");
    apply(16'h2FFF, 1, "R3");
    apply(16'h3000, 1, "R3");
    apply(16'h3FFF, 1, "R3");
  endtask

  task automatic t_sub();          // R4 R7
    for (int k = 0; k < 8; k++) begin
      apply(16'h8000 + 16'(k * 'h400), 1, "R4");
      apply(16'h83FF + 16'(k * 'h400), 1, "R7");
    end
    apply(16'h9FFF, 1, "R4");
    apply(16'hA000, 1, "R4");
  endtask

  task automatic t_alias();        // R5
    for (int k = 0; k < 1024; k += 37) begin
      apply(16'h8400 + 16'(k), 1, "R5");
      apply(16'h8800 + 16'(k), 1, "R5");
    end
    apply(16'h87FF, 1, "R5");
    apply(16'h8BFF, 1, "R5");
    apply(16'h8C00, 1, "R5");
  endtask

  task automatic t_spare_top();    // R7
    apply(16'h0000, 1, "R7");
    apply(16'h1FFF, 1, "R7");
    apply(16'hA000, 1, "R7");
    apply(16'hBFFF, 1, "R7");
    apply(16'hC000, 1, "R7");
    apply(16'hE000, 1, "R7");
    apply(16'hFFFF, 1, "R7");
  endtask

  task automatic t_sweep();        // R6 R1
    for (int u = 0; u < 65536; u += 4) apply(16'(u), 1, "R6");
    for (int u = 1; u < 65536; u += 1021) apply(16'(u), 0, "R1");
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1;
    t_reset_idle();
    t_ram();
    t_rom_big();
    t_sub();
    t_alias();
    t_spare_top();
    t_sweep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule